// File: doc/BRIEF.md
# Security Protection Controller

This block is a small register file on an APB slave port that holds the security state of a chip's bus slots and of its on-chip SRAM. Three groups of eight slot bits describe which masters or slaves are non-secure. A bit value of 1 marks the slot as non-secure, and 0 marks it as secure. Firmware never writes a group directly. It sets bits through one register and clears bits through a second register, so changing one slot cannot disturb the other slots. The whole 24-bit slot vector leaves the block as a level output, and the bus firewalls elsewhere in the chip read it.

The block also holds a 10-bit secure-region size for the SRAM, counted in 4 KB pages. A combinational output compares an SRAM byte offset against that size and reports whether the offset lies in the secure part of the memory. Any size with its top bit set makes the whole memory secure. After reset, every slot is secure and the whole SRAM is secure, so the chip starts in a fail-secure state until boot code opens it up.

Top module: `tzprot_ctrl`

## Requirements
- R1: After reset, `slot_ns` is all zero and the region size reads 0x200, so `sram_secure` is 1 for every offset.
- R2: A write to a group's set register makes every slot non-secure whose bit is 1 in `pwdata[7:0]`, and leaves the other slots unchanged. The set registers are at offset 0x804 for group 0, 0x810 for group 1 and 0x81C for group 2. Group g occupies bits `slot_ns[8g+7:8g]`. The new value shows on `slot_ns` in the cycle after the access phase.
- R3: A write to a group's clear register makes every slot secure whose bit is 1 in `pwdata[7:0]`, and leaves the other slots unchanged. The clear registers are at 0x808, 0x814 and 0x820.
- R4: A read of a status register returns the group's vector in `prdata[7:0]` with zeros above it. The status registers are at 0x800, 0x80C and 0x818. A read of a set or clear register returns 0. A write to a status register has no effect and does not raise an error.
- R5: The region size register at offset 0x000 keeps `pwdata[9:0]` and ignores the upper write bits. A read returns the size zero-extended.
- R6: While size bit 9 is 0, `sram_secure` is 1 exactly when `sram_offset` < size × 4096. A size of 0 never flags an offset, a size of 1 covers offsets 0 to 0xFFF, and a size of 0x1FF covers offsets below 0x1FF000.
- R7: While size bit 9 is 1 (any size of 0x200 or more), `sram_secure` is 1 for every offset.
- R8: `pready` is always 1. An access to an unmapped offset reads as 0, changes no state, and drives `pslverr` high during its access phase. `pslverr` is 0 at every other time.
- R9: A register changes only in an access phase, that is when `psel`, `penable` and `pwrite` are all 1. A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error for an unmapped offset |
| sram_offset | input | 22 | SRAM byte offset to classify |
| slot_ns | output | 24 | Non-secure flag for each slot, 1 = non-secure |
| sram_secure | output | 1 | 1 when `sram_offset` is in the secure region |

## Verification
On every cycle, the assertions check the following:
- a set write raises the written bits, a clear write drops them, and untouched bits keep their value;
- a group with no write holds its vector;
- the size register takes its write data and otherwise holds;
- a size with bit 9 set always flags secure, and a size of 0 never does;
- the error flag is raised only in an access phase and only with zero read data.

Some behaviour can only be shown by the bench's scenarios:
- the mapping from each offset to its group and bit lane;
- the reset values as seen at the ports;
- the exact page boundaries at sizes 1, 5 and 0x1FF;
- that status writes, unmapped writes and setup-only phases leave the state alone.

// File: rtl/tzprot_pkg.sv
package tzprot_pkg;

  localparam int unsigned APB_AW     = 12;
  localparam int unsigned MAX_GRP    = 16;
  localparam int unsigned GRP_IDX_W  = 4;
  localparam int unsigned GRP_STRIDE = 12;

  localparam logic [APB_AW-1:0] OFS_RGN_SIZE = 12'h000;
  localparam logic [APB_AW-1:0] OFS_GRP_BASE = 12'h800;
  localparam logic [APB_AW-1:0] OFS_SET_DELTA = 12'h004;
  localparam logic [APB_AW-1:0] OFS_CLR_DELTA = 12'h008;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SIZE,
    RK_STAT,
    RK_SET,
    RK_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e              kind;
    logic [GRP_IDX_W-1:0]   grp;
  } reg_hit_t;

  // Map a byte offset to the register it names; groups repeat every GRP_STRIDE bytes
  function automatic reg_hit_t decode_ofs(input logic [APB_AW-1:0] ofs,
                                          input int unsigned ngrp);
    reg_hit_t h;
    h.kind = RK_NONE;
    h.grp  = '0;
    if (ofs == OFS_RGN_SIZE) h.kind = RK_SIZE;
    for (int g = 0; g < MAX_GRP; g++) begin
      if (g < ngrp) begin
        logic [APB_AW-1:0] b;
        b = OFS_GRP_BASE + APB_AW'(g * GRP_STRIDE);
        if (ofs == b) begin
          h.kind = RK_STAT; h.grp = GRP_IDX_W'(g);
        end else if (ofs == b + OFS_SET_DELTA) begin
          h.kind = RK_SET;  h.grp = GRP_IDX_W'(g);
        end else if (ofs == b + OFS_CLR_DELTA) begin
          h.kind = RK_CLR;  h.grp = GRP_IDX_W'(g);
        end
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/tzprot_apb_dec.sv
module tzprot_apb_dec
  import tzprot_pkg::*;
#(
  parameter int unsigned NUM_GRP = 3
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  output reg_hit_t          hit,
  output logic              wr_stb,
  output logic              acc_err
);

  logic access;

  assign hit     = decode_ofs(paddr, NUM_GRP);
  assign access  = psel && penable;
  assign wr_stb  = access && pwrite;
  assign acc_err = access && (hit.kind == RK_NONE);

endmodule

// File: rtl/tzprot_group.sv
module tzprot_group #(
  parameter int unsigned GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [GRP_W-1:0] wmask,
  output logic [GRP_W-1:0] vec
);

  // Clear wins when both strobes are active in one cycle
  function automatic logic [GRP_W-1:0] grp_next(input logic [GRP_W-1:0] cur,
                                                input logic [GRP_W-1:0] setm,
                                                input logic [GRP_W-1:0] clrm);
    return (cur | setm) & ~clrm;
  endfunction

  logic [GRP_W-1:0] set_m, clr_m, vec_d;

  assign set_m = set_we ? wmask : '0;
  assign clr_m = clr_we ? wmask : '0;
  assign vec_d = grp_next(vec, set_m, clr_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= vec_d;
  end

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((vec & $past(wmask)) == $past(wmask)));

  assert_set_keeps_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((vec & ~$past(wmask)) == ($past(vec) & ~$past(wmask))));

  assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((vec & $past(wmask)) == '0));

  assert_clr_keeps_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((vec & ~$past(wmask)) == ($past(vec) & ~$past(wmask))));

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(vec));

endmodule

// File: rtl/tzprot_region.sv
module tzprot_region #(
  parameter int unsigned SIZE_W     = 10,
  parameter int unsigned SRAM_OFF_W = 22,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SIZE_W-1:0]     wdata,
  input  logic [SRAM_OFF_W-1:0] sram_offset,
  output logic [SIZE_W-1:0]     size_q,
  output logic                  sram_secure
);

  localparam int unsigned PAGE_W = SRAM_OFF_W - PAGE_SHIFT;
  localparam int unsigned CMP_W  = (PAGE_W > SIZE_W) ? PAGE_W : SIZE_W;
  localparam logic [SIZE_W-1:0] RST_SIZE = SIZE_W'(1) << (SIZE_W - 1);

  // Top size bit overrides; otherwise the page index must lie below the size
  function automatic logic page_secure(input logic [PAGE_W-1:0] page,
                                       input logic [SIZE_W-1:0] sz);
    return sz[SIZE_W-1] || (CMP_W'(page) < CMP_W'(sz));
  endfunction

  logic [PAGE_W-1:0]     page_idx;
  logic [PAGE_SHIFT-1:0] unused_byte_ofs;

  assign page_idx        = sram_offset[SRAM_OFF_W-1:PAGE_SHIFT];
  assign unused_byte_ofs = sram_offset[PAGE_SHIFT-1:0];
  assign sram_secure     = page_secure(page_idx, size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  size_q <= RST_SIZE;
    else if (we) size_q <= wdata;
  end

  assert_size_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (size_q == $past(wdata)));

  assert_size_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(size_q));

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    size_q[SIZE_W-1] |-> sram_secure);

  assert_empty_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0) |-> !sram_secure);

endmodule

// File: rtl/tzprot_ctrl.sv
module tzprot_ctrl
  import tzprot_pkg::*;
#(
  parameter int unsigned NUM_GRP    = 3,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned SIZE_W     = 10,
  parameter int unsigned SRAM_OFF_W = 22,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [APB_AW-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          prdata,
  output logic                       pready,
  output logic                       pslverr,
  input  logic [SRAM_OFF_W-1:0]      sram_offset,
  output logic [NUM_GRP*GRP_W-1:0]   slot_ns,
  output logic                       sram_secure
);

  localparam int unsigned UNUSED_LO = (GRP_W > SIZE_W) ? GRP_W : SIZE_W;

  reg_hit_t          hit;
  logic              wr_stb;
  logic              acc_err;
  logic              size_we;
  logic [SIZE_W-1:0] size_q;
  logic [GRP_W-1:0]  grp_vec [NUM_GRP];
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^pwdata[DATA_W-1:UNUSED_LO];

  tzprot_apb_dec #(.NUM_GRP(NUM_GRP)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .hit     (hit),
    .wr_stb  (wr_stb),
    .acc_err (acc_err)
  );

  assign size_we = wr_stb && (hit.kind == RK_SIZE);

  tzprot_region #(
    .SIZE_W     (SIZE_W),
    .SRAM_OFF_W (SRAM_OFF_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_region (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (size_we),
    .wdata       (pwdata[SIZE_W-1:0]),
    .sram_offset (sram_offset),
    .size_q      (size_q),
    .sram_secure (sram_secure)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic grp_sel, set_we, clr_we;
    assign grp_sel = wr_stb && (hit.grp == GRP_IDX_W'(g));
    assign set_we  = grp_sel && (hit.kind == RK_SET);
    assign clr_we  = grp_sel && (hit.kind == RK_CLR);

    tzprot_group #(.GRP_W(GRP_W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wmask  (pwdata[GRP_W-1:0]),
      .vec    (grp_vec[g])
    );

    assign slot_ns[g*GRP_W +: GRP_W] = grp_vec[g];
  end

  always_comb begin
    prdata = '0;
    if (hit.kind == RK_SIZE) begin
      prdata[SIZE_W-1:0] = size_q;
    end else if (hit.kind == RK_STAT) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (hit.grp == GRP_IDX_W'(g)) prdata[GRP_W-1:0] = grp_vec[g];
      end
    end
  end

  assign pready  = 1'b1;
  assign pslverr = acc_err;

  assert_err_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |-> !pslverr);

  assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0));

  assert_setup_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |=> ($stable(slot_ns) && $stable(size_q)));

endmodule

// File: tb/tzprot_ctrl_tb.sv
module tzprot_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [21:0] sram_offset = '0;
  logic [23:0] slot_ns;
  logic        sram_secure;

  int checks = 0;
  int failures = 0;

  // Expected results of each access, popped by the monitor
  logic [31:0] sb_data [$];
  logic        sb_err  [$];
  logic        sb_rd   [$];
  string       sb_tag  [$];

  // Reference state of the three groups and the size register
  logic [7:0]  m_vec [3];
  logic [9:0]  m_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  tzprot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .sram_offset(sram_offset), .slot_ns(slot_ns),
    .sram_secure(sram_secure)
  );

  function automatic logic [23:0] m_ns();
    return {m_vec[2], m_vec[1], m_vec[0]};
  endfunction

  // Restated region rule: whole memory when size >= 512, else offset below size pages
  function automatic logic m_secure(input logic [21:0] ofs);
    if (m_size >= 10'd512) return 1'b1;
    return ({10'd0, ofs} < ({22'd0, m_size} * 32'd4096));
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each access phase against the scoreboard
  always @(negedge clk) begin
    if (rst_n && psel && penable) begin
      if (sb_data.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 unexpected access actual=1 expected=0");
      end else begin
        logic [31:0] d; logic e; logic r; string t;
        d = sb_data.pop_front(); e = sb_err.pop_front();
        r = sb_rd.pop_front();   t = sb_tag.pop_front();
        chk({31'd0, pslverr}, {31'd0, e}, {t, " pslverr"});
        chk({31'd0, pready}, 32'd1, "R8 pready");
        if (r) chk(prdata, d, {t, " prdata"});
      end
    end
  end

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                     input logic [31:0] exp_rd, input logic exp_err, input string tag);
    sb_data.push_back(exp_rd); sb_err.push_back(exp_err);
    sb_rd.push_back(!wr);      sb_tag.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input logic e, input string tag);
    apb(1'b1, a, wd, 32'd0, e, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic e, input string tag);
    apb(1'b0, a, 32'd0, exp, e, tag);
  endtask

  task automatic chk_region(input logic [21:0] ofs, input string tag);
    sram_offset = ofs; #1;
    chk({31'd0, sram_secure}, {31'd0, m_secure(ofs)}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_vec[0] = 8'h00; m_vec[1] = 8'h00; m_vec[2] = 8'h00; m_size = 10'h200;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({8'd0, slot_ns}, 32'd0, "R1 slot_ns after reset");
    chk_region(22'h3FFFFF, "R1 secure at top offset");
    chk_region(22'h000000, "R1 secure at offset 0");
    rd(12'h000, 32'h200, 1'b0, "R1 size reset value");
    chk({31'd0, pslverr}, 32'd0, "R8 pslverr idle");

    // R2 set registers
    wr(12'h804, 32'hFFFF_FFA5, 1'b0, "R2 set g0"); m_vec[0] |= 8'hA5;
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R2 set g0 A5");
    wr(12'h810, 32'h0000_000F, 1'b0, "R2 set g1"); m_vec[1] |= 8'h0F;
    wr(12'h81C, 32'h0000_0080, 1'b0, "R2 set g2"); m_vec[2] |= 8'h80;
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R2 set g1 g2 lanes");
    wr(12'h804, 32'h0000_005A, 1'b0, "R2 set g0 again"); m_vec[0] |= 8'h5A;
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R2 zero bits keep value");

    // R3 clear registers
    wr(12'h808, 32'h0000_000F, 1'b0, "R3 clr g0"); m_vec[0] &= ~8'h0F;
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R3 clr g0 low nibble");
    wr(12'h820, 32'hFFFF_FFFF, 1'b0, "R3 clr g2"); m_vec[2] = 8'h00;
    wr(12'h814, 32'h0000_0001, 1'b0, "R3 clr g1 bit0"); m_vec[1] &= ~8'h01;
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R3 clr g1 g2");

    // R4 status and set/clear readback
    rd(12'h800, {24'd0, m_vec[0]}, 1'b0, "R4 status g0");
    rd(12'h80C, {24'd0, m_vec[1]}, 1'b0, "R4 status g1");
    rd(12'h818, {24'd0, m_vec[2]}, 1'b0, "R4 status g2");
    rd(12'h804, 32'd0, 1'b0, "R4 set reg reads 0");
    rd(12'h814, 32'd0, 1'b0, "R4 clr reg reads 0");
    wr(12'h80C, 32'h0000_00FF, 1'b0, "R4 status write");
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R4 status write ignored");

    // R5 size register
    wr(12'h000, 32'hFFFF_FC05, 1'b0, "R5 size write"); m_size = 10'h005;
    rd(12'h000, 32'h005, 1'b0, "R5 size upper bits dropped");

    // R6 boundaries
    chk_region(22'h004FFF, "R6 size5 last secure byte");
    chk_region(22'h005000, "R6 size5 first open byte");
    wr(12'h000, 32'h0, 1'b0, "R6 size 0"); m_size = 10'h000;
    chk_region(22'h000000, "R6 size0 offset0 open");
    wr(12'h000, 32'h1, 1'b0, "R6 size 1"); m_size = 10'h001;
    chk_region(22'h000FFF, "R6 size1 0xFFF secure");
    chk_region(22'h001000, "R6 size1 0x1000 open");
    wr(12'h000, 32'h1FF, 1'b0, "R6 size 1FF"); m_size = 10'h1FF;
    chk_region(22'h1FEFFF, "R6 size1FF last secure");
    chk_region(22'h1FF000, "R6 size1FF first open");

    // R7 override
    wr(12'h000, 32'h200, 1'b0, "R7 size 200"); m_size = 10'h200;
    chk_region(22'h3FFFFF, "R7 size200 whole memory");
    wr(12'h000, 32'h3FF, 1'b0, "R7 size 3FF"); m_size = 10'h3FF;
    chk_region(22'h2ABCDE, "R7 size3FF whole memory");

    // R8 unmapped offsets
    rd(12'h004, 32'd0, 1'b1, "R8 unmapped read 004");
    rd(12'h824, 32'd0, 1'b1, "R8 unmapped read 824");
    wr(12'h900, 32'hFFFF_FFFF, 1'b1, "R8 unmapped write");
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R8 unmapped write no effect");
    rd(12'h000, {22'd0, m_size}, 1'b0, "R8 size unchanged");

    // R9 setup phase without access phase
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h810; pwdata = 32'hFF;
    @(posedge clk); #1;
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    chk({8'd0, slot_ns}, {8'd0, m_ns()}, "R9 setup-only write ignored");

    repeat (2) @(posedge clk);
    if (sb_data.size() != 0) begin
      checks++; failures++;
      $display("FAIL R8 scoreboard leftover actual=%0d expected=0", sb_data.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule